// File: doc/BRIEF.md
# Microscaled FP4 Block Quantizer

This block turns a group of 32 bfloat16 numbers into a compact microscaled form: one unsigned 8-bit power-of-two scale, biased by 127 like a single-precision exponent, and 32 signed 4-bit e2m1 codes. The magnitudes the codes can hold are 0, 0.5, 1, 1.5, 2, 3, 4 and 6. Data enters two bf16 values per beat over a valid/ready handshake. The running maximum magnitude is gathered while the block streams in. A replay pass then divides each buffered element by the shared power of two and rounds it into a 4-bit code. The result leaves as a 128-bit payload and a scale byte, marked by a one-cycle valid pulse.

The block is controlled by a four-state machine. ST_FILL accepts 16 beats. The 16th accepted beat moves it to ST_SCALE. ST_SCALE spends one cycle registering the scale and the fallback flag, then always moves to ST_ENCODE. ST_ENCODE codes one buffered pair per cycle. After the 16th pair it moves to ST_EMIT and raises the output valid. ST_EMIT always returns to ST_FILL.

Top module: `fp4_block_quantizer`

## Requirements
- R1: A beat is taken on a rising edge where in_valid and in_ready are both high. in_data[15:0] is the even element and in_data[31:16] the odd one, and 16 beats make one block. in_ready is high in ST_FILL, and only there. It is low from the edge that takes the 16th beat until the edge after the out_valid pulse.
- R2: The block peak is the largest of the 32 sign-cleared 15-bit patterns (bits 14:0), compared as unsigned integers.
- R3: When the peak's exponent field (bits 14:7) is nonzero and t = (peak + 0x20) >> 7 is at least 2, out_scale equals (t - 2) mod 256.
- R4: When the peak's exponent field is zero or t is below 2, out_scale is 0 and every code is {sign, 3'b000}.
- R5: Otherwise each code is {sign of the input, m}. Here m is the 3-bit magnitude code 000..111 for 0, 0.5, 1, 1.5, 2, 3, 4, 6 that lies nearest to |x| / 2^(scale-127). On a tie the code with bit 0 clear wins.
- R6: A scaled magnitude above 6 gives magnitude code 111.
- R7: An input whose bf16 exponent field is zero encodes as {sign, 3'b000}.
- R8: Element i of the block occupies out_payload[4*i+3:4*i]. Element 0 is therefore the low nibble of byte 0 of 32-bit word 0.
- R9: out_valid is a single-cycle pulse that rises 17 rising edges after the edge that takes the 16th beat. out_payload and out_scale change only as out_valid rises and hold their values otherwise.
- R10: Beats offered while in_ready is low are not taken and do not affect any block's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pair offered |
| in_ready | output | 1 | Block can take a pair this cycle |
| in_data | input | 32 | Two bf16 values, even element in the low half |
| out_valid | output | 1 | One-cycle pulse: payload and scale are new |
| out_payload | output | 128 | 32 packed 4-bit codes |
| out_scale | output | 8 | Shared power-of-two scale, bias 127 |

## Verification
Every result of a block is due at one fixed point in time. The pulse, the new payload and the new scale all appear 17 rising edges after the edge that takes the final beat. in_ready is low for 18 edges, so it returns one edge after the pulse. The bench counts rising edges from the accepting edge and samples every output on the falling edge that follows each counted edge. It therefore checks the latency exactly and reads the payload and scale in the pulse cycle itself. While the bench waits, it also checks that in_ready stays low. In some runs it keeps offering junk beats during that wait, and it then checks that the next block's result matches its own reference.

// File: rtl/fp4q_pkg.sv
package fp4q_pkg;

    // bf16 layout
    localparam int BF16_W   = 16;
    localparam int EXP_W    = 8;
    localparam int MANT_W   = 7;
    localparam int MAG_W    = BF16_W - 1;

    // e2m1 element and shared scale
    localparam int CODE_W   = 4;
    localparam int SCALE_W  = 8;

    // rounding offset added to the peak pattern before exponent extraction
    localparam logic [BF16_W-1:0] PEAK_ROUND_OFS = 16'h0020;
    // log2 of the largest e2m1 power of two (4)
    localparam int E2M1_TOP_LOG2 = 2;

    typedef logic [BF16_W-1:0] bf16_t;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  expo;
        logic [MANT_W-1:0] mant;
    } bf16_fields_t;

    typedef enum logic [1:0] {
        ST_FILL   = 2'd0,
        ST_SCALE  = 2'd1,
        ST_ENCODE = 2'd2,
        ST_EMIT   = 2'd3
    } fp4q_state_e;

endpackage

// File: rtl/fp4q_collect.sv
module fp4q_collect
    import fp4q_pkg::*;
#(
    parameter int LANES = 2,
    parameter int BEATS = 16,
    localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1,
    localparam int ROW_W = BF16_W * LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [ROW_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [ROW_W-1:0] rd_data,
    output logic [MAG_W-1:0] peak
);

    logic [ROW_W-1:0] row_mem [BEATS];
    logic [MAG_W-1:0] peak_q;
    logic [MAG_W-1:0] peak_d;
    logic [MAG_W-1:0] lane_mag [LANES];

    // sign-cleared magnitude of every lane
    for (genvar l = 0; l < LANES; l++) begin : g_mag
        assign lane_mag[l] = wr_data[BF16_W*l +: MAG_W];
    end

    // running unsigned maximum, restarted on the first beat of a block
    always_comb begin
        peak_d = (wr_idx == '0) ? '0 : peak_q;
        for (int l = 0; l < LANES; l++) begin
            if (lane_mag[l] > peak_d) begin
                peak_d = lane_mag[l];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            peak_q <= '0;
        end else if (wr_en) begin
            peak_q <= peak_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            row_mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = row_mem[rd_idx];
    assign peak    = peak_q;

    // the tracked peak never falls below any magnitude just written
    for (genvar l = 0; l < LANES; l++) begin : g_chk
        AST_PEAK_COVERS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |=> (peak_q >= $past(wr_data[BF16_W*l +: MAG_W]))); // R2
    end

endmodule

// File: rtl/fp4q_scale.sv
module fp4q_scale
    import fp4q_pkg::*;
(
    input  logic [MAG_W-1:0]   peak,
    output logic [SCALE_W-1:0] scale,
    output logic               flush
);

    logic [BF16_W:0]   biased;
    logic [EXP_W:0]    top_exp;
    logic [EXP_W-1:0]  peak_exp;

    assign peak_exp = peak[MAG_W-1:MANT_W];
    assign biased   = {2'b00, peak} + {1'b0, PEAK_ROUND_OFS};
    assign top_exp  = biased[BF16_W-1:MANT_W];

    always_comb begin
        flush = (peak_exp == '0) || (top_exp < (EXP_W+1)'(E2M1_TOP_LOG2));
        if (flush) begin
            scale = '0;
        end else begin
            scale = SCALE_W'(top_exp - (EXP_W+1)'(E2M1_TOP_LOG2));
        end
    end

endmodule

// File: rtl/fp4q_elem_enc.sv
module fp4q_elem_enc
    import fp4q_pkg::*;
(
    input  bf16_t              x,
    input  logic [SCALE_W-1:0] scale,
    input  logic               flush,
    output logic [CODE_W-1:0]  code
);

    bf16_fields_t      f;
    logic signed [9:0] dexp;
    logic [2:0]        base;
    logic [3:0]        bumped;
    logic              rnd_bit;
    logic              sticky;
    logic              round_up;
    logic [2:0]        mag;

    assign f    = x;
    assign dexp = $signed({2'b00, f.expo}) - $signed({2'b00, scale});

    always_comb begin
        base     = {dexp[1:0] + 2'd1, f.mant[6]};
        rnd_bit  = f.mant[5];
        sticky   = |f.mant[4:0];
        round_up = rnd_bit & (sticky | f.mant[6]);
        bumped   = {1'b0, base} + {3'b000, round_up};

        if (flush || (f.expo == '0)) begin
            mag = 3'b000;
        end else if (dexp >= 10'sd3) begin
            mag = 3'b111;
        end else if (dexp >= 10'sd0) begin
            mag = bumped[3] ? 3'b111 : bumped[2:0];
        end else if (dexp == -10'sd1) begin
            mag = f.mant[6] ? 3'b010 : 3'b001;
        end else if (dexp == -10'sd2) begin
            mag = (|f.mant) ? 3'b001 : 3'b000;
        end else begin
            mag = 3'b000;
        end
    end

    assign code = {f.sign, mag};

endmodule

// File: rtl/fp4_block_quantizer.sv
module fp4_block_quantizer
    import fp4q_pkg::*;
#(
    parameter int ELEMS = 32,
    parameter int LANES = 2,
    localparam int BEATS = ELEMS / LANES,
    localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1,
    localparam int IN_W  = BF16_W * LANES,
    localparam int PAY_W = CODE_W * ELEMS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [IN_W-1:0]    in_data,
    output logic               out_valid,
    output logic [PAY_W-1:0]   out_payload,
    output logic [SCALE_W-1:0] out_scale
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BEATS - 1);

    fp4q_state_e         state_q;
    fp4q_state_e         state_d;
    logic [IDX_W-1:0]    beat_q;
    logic [IDX_W-1:0]    enc_q;
    logic [SCALE_W-1:0]  scale_q;
    logic                flush_q;
    logic [PAY_W-1:0]    work_q;
    logic [PAY_W-1:0]    work_d;

    logic                in_fire;
    logic                last_beat;
    logic                last_pair;
    logic [IN_W-1:0]     rd_data;
    logic [MAG_W-1:0]    peak;
    logic [SCALE_W-1:0]  scale_calc;
    logic                flush_calc;
    logic [CODE_W-1:0]   lane_code [LANES];

    assign in_ready  = (state_q == ST_FILL);
    assign in_fire   = in_valid && in_ready;
    assign last_beat = in_fire && (beat_q == LAST_IDX);
    assign last_pair = (state_q == ST_ENCODE) && (enc_q == LAST_IDX);

    // ---------------- storage and peak tracking ----------------
    fp4q_collect #(
        .LANES (LANES),
        .BEATS (BEATS)
    ) u_collect (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (in_fire),
        .wr_idx  (beat_q),
        .wr_data (in_data),
        .rd_idx  (enc_q),
        .rd_data (rd_data),
        .peak    (peak)
    );

    // ---------------- shared scale ----------------
    fp4q_scale u_scale (
        .peak  (peak),
        .scale (scale_calc),
        .flush (flush_calc)
    );

    // ---------------- per-lane element encoders ----------------
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        fp4q_elem_enc u_enc (
            .x     (rd_data[BF16_W*l +: BF16_W]),
            .scale (scale_q),
            .flush (flush_q),
            .code  (lane_code[l])
        );
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL:   if (last_beat) state_d = ST_SCALE;
            ST_SCALE:  state_d = ST_ENCODE;
            ST_ENCODE: if (enc_q == LAST_IDX) state_d = ST_EMIT;
            ST_EMIT:   state_d = ST_FILL;
            default:   state_d = ST_FILL;
        endcase
    end

    // merge this cycle's codes into the working payload
    always_comb begin
        work_d = work_q;
        for (int l = 0; l < LANES; l++) begin
            work_d[(int'(enc_q) * LANES + l) * CODE_W +: CODE_W] = lane_code[l];
        end
    end

    // ---------------- state register and datapath ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
            beat_q  <= '0;
            enc_q   <= '0;
            scale_q <= '0;
            flush_q <= 1'b0;
            work_q  <= '0;
        end else begin
            state_q <= state_d;
            if (in_fire) begin
                beat_q <= last_beat ? '0 : beat_q + 1'b1;
            end
            if (state_q == ST_SCALE) begin
                scale_q <= scale_calc;
                flush_q <= flush_calc;
                enc_q   <= '0;
                work_q  <= '0;
            end else if (state_q == ST_ENCODE) begin
                work_q <= work_d;
                enc_q  <= last_pair ? '0 : enc_q + 1'b1;
            end
        end
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_payload <= '0;
            out_scale   <= '0;
        end else begin
            out_valid <= last_pair;
            if (last_pair) begin
                out_payload <= work_d;
                out_scale   <= scale_q;
            end
        end
    end

    // ---------------- assertions ----------------
    AST_VALID_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R9

    AST_BUSY_DURING_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R1

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_payload) && $stable(out_scale))); // R9

    for (genvar l = 0; l < LANES; l++) begin : g_chk
        AST_FLUSH_GIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            ((state_q == ST_ENCODE) && flush_q) |-> (lane_code[l][2:0] == 3'b000)); // R4

        AST_PEAK_CODE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            ((state_q == ST_ENCODE) && !flush_q &&
             (rd_data[BF16_W*l +: MAG_W] == peak)) |-> (lane_code[l][2:0] >= 3'b110)); // R5
    end

endmodule

// File: tb/test_fp4_block_quantizer.sv
module test_fp4_block_quantizer;

    logic         clk;
    logic         rst_n;
    logic         in_valid;
    logic         in_ready;
    logic [31:0]  in_data;
    logic         out_valid;
    logic [127:0] out_payload;
    logic [7:0]   out_scale;

    int checks;
    int fails;

    logic [15:0]  stim [32];
    logic [7:0]   exp_scale;
    logic [127:0] exp_pay;

    // {base exponent, exponent spread, lfsr seed}
    localparam logic [31:0] VEC_TAB [8] = '{
        {8'd127, 8'd4,  16'hACE1},
        {8'd100, 8'd10, 16'h1234},
        {8'd130, 8'd1,  16'h0F0F},
        {8'd140, 8'd20, 16'hBEEF},
        {8'd3,   8'd3,  16'h7777},
        {8'd200, 8'd6,  16'h2468},
        {8'd60,  8'd40, 16'h9ABC},
        {8'd127, 8'd2,  16'h5555}
    };

    fp4_block_quantizer i_fp4_block_quantizer (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_data     (in_data),
        .out_valid   (out_valid),
        .out_payload (out_payload),
        .out_scale   (out_scale)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic real pow2(input int e);
        real r = 1.0;
        if (e >= 0) repeat (e) r = r * 2.0;
        else        repeat (-e) r = r / 2.0;
        return r;
    endfunction

    // reference built from the requirements: real division, nearest table value
    task automatic compute_ref();
        logic [14:0] pk = '0;
        int  t;
        bit  fb;
        real grid [8] = '{0.0, 0.5, 1.0, 1.5, 2.0, 3.0, 4.0, 6.0};
        for (int i = 0; i < 32; i++) if (stim[i][14:0] > pk) pk = stim[i][14:0];
        t  = (int'(pk) + 32) >> 7;
        fb = (pk[14:7] == 8'd0) || (t < 2);
        exp_scale = fb ? 8'd0 : 8'(t - 2);
        exp_pay = '0;
        for (int i = 0; i < 32; i++) begin
            logic [2:0] best = 3'd0;
            if (!fb && stim[i][14:7] != 8'd0) begin
                real v = (1.0 + real'(stim[i][6:0]) / 128.0) *
                         pow2(int'(stim[i][14:7]) - int'(exp_scale));
                real bd = 1.0e30;
                for (int k = 0; k < 8; k++) begin
                    real dd = (v > grid[k]) ? v - grid[k] : grid[k] - v;
                    if (dd < bd || (dd == bd && k[0] == 1'b0)) begin
                        bd = dd;
                        best = 3'(k);
                    end
                end
            end
            exp_pay[4*i +: 4] = {stim[i][15], best};
        end
    endtask

    // drives stim[], measures latency, compares with the reference
    task automatic run_block(input string tag, input bit junk_when_busy);
        int  n;
        bit  ready_low_ok;
        compute_ref();
        for (int b = 0; b < 16; b++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = {stim[2*b+1], stim[2*b]};
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        if (junk_when_busy) begin
            in_valid = 1'b1;
            in_data  = 32'h7F00_7F00;
        end else begin
            in_valid = 1'b0;
        end
        n = 0;
        ready_low_ok = 1'b1;
        while (n < 40) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (junk_when_busy) in_data = {in_data[30:0], in_data[31]} ^ 32'h0101_0000;
            if (out_valid) begin
                in_valid = 1'b0;
                break;
            end
            if (in_ready) ready_low_ok = 1'b0;
        end
        if (in_ready) ready_low_ok = 1'b0;
        check(n == 17, "R9", {tag, " latency"}, 128'(n), 128'd17);
        check(ready_low_ok, "R1", {tag, " ready low while busy"}, 128'(ready_low_ok), 128'd1);
        check(out_scale == exp_scale, "R2/R3/R4", {tag, " scale"}, 128'(out_scale), 128'(exp_scale));
        check(out_payload == exp_pay, "R5/R8", {tag, " payload"}, out_payload, exp_pay);
        @(negedge clk);
        check(!out_valid, "R9", {tag, " pulse width"}, 128'(out_valid), 128'd0);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        checks   = 0;
        fails    = 0;
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_data  = '0;
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R9", "reset valid", 128'(out_valid), 128'd0);
        check(out_payload == '0 && out_scale == '0, "R9", "reset outputs",
              out_payload, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R1", "ready after reset", 128'(in_ready), 128'd1);

        // table walk
        foreach (VEC_TAB[v]) begin
            logic [15:0] lf   = VEC_TAB[v][15:0];
            logic [7:0]  base = VEC_TAB[v][31:24];
            logic [7:0]  spr  = VEC_TAB[v][23:16];
            for (int i = 0; i < 32; i++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                stim[i] = {lf[0], 8'(base - 8'(lf[7:1] % spr)), lf[14:8]};
            end
            run_block($sformatf("vec%0d", v), v[0]);
        end

        // R10: the block after junk offers must still match its reference
        for (int i = 0; i < 32; i++) stim[i] = 16'h3F80 + 16'(i);
        run_block("R10 after junk", 1'b0);

        // R4: all zero with mixed signs
        for (int i = 0; i < 32; i++) stim[i] = i[0] ? 16'h8000 : 16'h0000;
        run_block("R4 zero block", 1'b0);
        check(out_scale == 8'd0, "R4", "zero block scale", 128'(out_scale), 128'd0);

        // R4: tiny exponent peak -> t below 2
        for (int i = 0; i < 32; i++) stim[i] = i[1] ? 16'h8085 : 16'h0011;
        stim[5] = 16'h0090;
        run_block("R4 small peak", 1'b0);
        check(out_scale == 8'd0 && out_payload[23:20] == 4'b0000, "R4", "small peak zeroing",
              {out_scale, out_payload[23:20]}, 128'd0);

        // R3 offset and R5 tie: 1.75 peak -> scale 126, 3.5 ties to 4 (110)
        for (int i = 0; i < 32; i++) stim[i] = 16'h3F80;
        stim[0] = 16'h3FE0;
        run_block("R3 offset", 1'b0);
        check(out_scale == 8'd126, "R3", "offset bumps scale", 128'(out_scale), 128'd126);
        check(out_payload[3:0] == 4'b0110, "R5", "tie to even", 128'(out_payload[3:0]), 128'h6);

        // R6 saturation and R7 zero-exponent inputs
        for (int i = 0; i < 32; i++) stim[i] = 16'h0000;
        stim[0] = 16'h3FDF;
        stim[1] = 16'hBFDF;
        stim[2] = 16'h0001;
        stim[3] = 16'h8001;
        run_block("R6 saturate", 1'b0);
        check(out_scale == 8'd125, "R3", "no bump scale", 128'(out_scale), 128'd125);
        check(out_payload[7:0] == 8'hF7, "R6", "saturated codes", 128'(out_payload[7:0]), 128'hF7);
        check(out_payload[15:8] == 8'h80, "R7", "zero exponent inputs",
              128'(out_payload[15:8]), 128'h80);

        // R8 packing: peak 6.0 gives scale 127, element i -> code {i[3], i[2:0]}
        begin
            logic [15:0]  vals [8] = '{16'h0000, 16'h3F00, 16'h3F80, 16'h3FC0,
                                       16'h4000, 16'h4040, 16'h4080, 16'h40C0};
            logic [127:0] lit = '0;
            for (int i = 0; i < 32; i++) begin
                stim[i] = vals[i % 8] | (i[3] ? 16'h8000 : 16'h0000);
                lit[4*i +: 4] = {i[3], 3'(i % 8)};
            end
            run_block("R8 packing", 1'b0);
            check(out_scale == 8'd127, "R8", "packing scale", 128'(out_scale), 128'd127);
            check(out_payload == lit, "R8", "nibble positions", out_payload, lit);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule